// File: doc/BRIEF.md
# Two-Layer Raster Scan Fetch Engine

This block drives a 640x480, 60 Hz raster display from a 100 MHz system clock. It divides that clock down to a 25 MHz pixel rate and produces active-low horizontal and vertical sync, a blanking flag and an 8-bit RGB code. It also keeps a small prefetch queue topped up by issuing single-word read requests toward a memory arbiter.

Each memory word holds two pixel codes side by side, one for a lower layer and one for an upper layer. A single fetch therefore serves both layers of one screen position. When the queue head is consumed, the upper code is shown wherever it is nonzero. Zero in the upper half is transparent and lets the lower code through.

Fetching is paced only by room in the queue. The fetch address returns to zero on the first blanked line after the visible area. The whole next frame is then prefetched as space permits.

Top module: `lsf_engine`

## Requirements
- R1: While reset is held and until the first pixel tick after it, hsync_n and vsync_n are 1, blank is 1, rgb and underflow_err are 0, fifo_full is 0, and a request for address 0 is presented.
- R2: A line lasts 800 pixel periods. Blank is 0 for exactly the first 640 periods of each visible line. hsync_n is 0 for 96 periods, starting 16 periods after the visible part ends.
- R3: A frame lasts 525 lines, of which 480 carry visible pixels. vsync_n is 0 for exactly 2 whole lines, starting 10 lines after the last visible line, and only while blank is 1.
- R4: The pixel period is CLK_DIV (4) system clocks. Sync, blank and rgb change only on a pixel tick, and the sync-to-sync spacing is 800*CLK_DIV clocks.
- R5: mem_req is high only while the words queued plus the words requested but not yet returned number fewer than FIFO_DEPTH, and only while the frame still has pixels to fetch. Once raised, mem_req stays high with mem_addr unchanged until mem_gnt, unless the frame restarts.
- R6: Granted addresses run 0, 1, 2 and on in order, exactly 640*480 of them per frame, and start again at 0 after the last visible line.
- R7: For a returned word, bits [15:8] are the upper code and bits [7:0] the lower code. The shown rgb is the upper code when it is nonzero and the lower code otherwise. Visible pixels appear in fetch order.
- R8: rgb is 0 whenever blank is 1.
- R9: If a visible pixel is due while the queue is empty, that pixel is shown as 0 and underflow_err goes to 1. underflow_err then stays 1 until reset.
- R10: fifo_full is 1 exactly when FIFO_DEPTH (8) words are queued, and no returned word is ever lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req | output | 1 | Read request toward the arbiter |
| mem_addr | output | ADDR_W (24) | Word address of the pending request |
| mem_gnt | input | 1 | Arbiter accepts the request this cycle |
| mem_rvalid | input | 1 | Read data returned this cycle, in request order |
| mem_rdata | input | 2*LAYER_W (16) | Returned word: upper code in the high half, lower code in the low half |
| fifo_full | output | 1 | Prefetch queue holds FIFO_DEPTH words |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| blank | output | 1 | High outside the visible area |
| rgb | output | LAYER_W (8) | Composed pixel code |
| underflow_err | output | 1 | Sticky flag: a visible pixel found the queue empty |

## Verification
The hardest case to reach from the ports is a queue underflow in the middle of visible video. When the memory answers at any reasonable rate, the prefetch keeps well ahead of the display. The bench first lets the queue fill during blanking and then checks one full frame of composed pixels. After that it withholds every grant for more than a frame, so the eight prefetched words drain while the raster is visible. From that point the starved pixels must read 0 and the error flag must rise, and the flag must stay up once grants resume. A pseudo-random grant pattern throughout the run makes requests wait, which exercises the hold-until-granted rule.

// File: rtl/lsf_pkg.sv
package lsf_pkg;

  typedef struct packed {
    logic hs_n;
    logic vs_n;
    logic act;
  } lsf_scan_t;

  // true when pos lies in [first, first+len)
  function automatic logic in_zone(int pos, int first, int len);
    return (pos >= first) && (pos < first + len);
  endfunction

endpackage

// File: rtl/lsf_timing.sv
module lsf_timing
  import lsf_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int H_ACT   = 640,
  parameter int H_FP    = 16,
  parameter int H_SYNC  = 96,
  parameter int H_BP    = 48,
  parameter int V_ACT   = 480,
  parameter int V_FP    = 10,
  parameter int V_SYNC  = 2,
  parameter int V_BP    = 33
) (
  input  logic      clk,
  input  logic      rst_n,
  output logic      pix_en,
  output lsf_scan_t scan,
  output logic      frame_restart
);

  localparam int H_TOT = H_ACT + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_ACT + V_FP + V_SYNC + V_BP;
  localparam int HW    = $clog2(H_TOT);
  localparam int VW    = $clog2(V_TOT);
  localparam int DW    = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  localparam logic [DW-1:0] DIV_LAST = DW'(CLK_DIV - 1);
  localparam logic [HW-1:0] H_LAST   = HW'(H_TOT - 1);
  localparam logic [VW-1:0] V_LAST   = VW'(V_TOT - 1);
  localparam logic [VW-1:0] V_VIS_LAST = VW'(V_ACT - 1);
  localparam logic [VW-1:0] V_START  = VW'(V_ACT);

  logic [DW-1:0] div_q;
  logic [HW-1:0] h_q;
  logic [VW-1:0] v_q;
  logic          line_end;

  assign pix_en   = (div_q == DIV_LAST);
  assign line_end = pix_en && (h_q == H_LAST);

  // start in the first blanked line so the queue fills before video
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      h_q   <= '0;
      v_q   <= V_START;
    end else begin
      div_q <= pix_en ? '0 : div_q + DW'(1);
      if (pix_en) h_q <= line_end ? '0 : h_q + HW'(1);
      if (line_end) v_q <= (v_q == V_LAST) ? '0 : v_q + VW'(1);
    end
  end

  always_comb begin
    scan.act  = in_zone(int'(h_q), 0, H_ACT) && in_zone(int'(v_q), 0, V_ACT);
    scan.hs_n = !in_zone(int'(h_q), H_ACT + H_FP, H_SYNC);
    scan.vs_n = !in_zone(int'(v_q), V_ACT + V_FP, V_SYNC);
  end

  assign frame_restart = line_end && (v_q == V_VIS_LAST);

endmodule

// File: rtl/lsf_fifo.sv
module lsf_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               wdata,
  input  logic                       pop,
  output logic [W-1:0]               rdata,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       empty,
  output logic                       full
);

  localparam int PW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] P_LAST = PW'(DEPTH - 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [LW-1:0] lvl_q;
  logic          do_pop;

  assign do_pop = pop && (lvl_q != '0);

  always_ff @(posedge clk) begin
    if (push) mem_q[wp_q] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (push)   wp_q <= (wp_q == P_LAST) ? '0 : wp_q + PW'(1);
      if (do_pop) rp_q <= (rp_q == P_LAST) ? '0 : rp_q + PW'(1);
      case ({push, do_pop})
        2'b10:   lvl_q <= lvl_q + LW'(1);
        2'b01:   lvl_q <= lvl_q - LW'(1);
        default: lvl_q <= lvl_q;
      endcase
    end
  end

  assign rdata = mem_q[rp_q];
  assign level = lvl_q;
  assign empty = (lvl_q == '0);
  assign full  = (lvl_q == LW'(DEPTH));

endmodule

// File: rtl/lsf_fetch.sv
module lsf_fetch #(
  parameter int ADDR_W    = 24,
  parameter int DEPTH     = 8,
  parameter int FRAME_PIX = 640 * 480
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       restart,
  input  logic [$clog2(DEPTH+1)-1:0] fifo_level,
  input  logic                       gnt,
  input  logic                       rsp_valid,
  output logic                       req,
  output logic [ADDR_W-1:0]          addr
);

  localparam int LVW  = $clog2(DEPTH + 1);
  localparam int SW   = LVW + 1;
  localparam int FC_W = $clog2(FRAME_PIX + 1);

  logic [LVW-1:0]  inflight_q;
  logic [FC_W-1:0] fcnt_q;
  logic [SW-1:0]   committed;
  logic            room, left, take;

  // words already queued plus words still on their way back
  assign committed = SW'(fifo_level) + SW'(inflight_q);
  assign room      = committed < SW'(DEPTH);
  assign left      = fcnt_q < FC_W'(FRAME_PIX);
  assign req       = room && left;
  assign take      = req && gnt;
  assign addr      = ADDR_W'(fcnt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inflight_q <= '0;
      fcnt_q     <= '0;
    end else begin
      case ({take, rsp_valid})
        2'b10:   inflight_q <= inflight_q + LVW'(1);
        2'b01:   inflight_q <= inflight_q - LVW'(1);
        default: inflight_q <= inflight_q;
      endcase
      if (restart)   fcnt_q <= '0;
      else if (take) fcnt_q <= fcnt_q + FC_W'(1);
    end
  end

endmodule

// File: rtl/lsf_engine.sv
module lsf_engine
  import lsf_pkg::*;
#(
  parameter int CLK_DIV    = 4,
  parameter int H_ACT      = 640,
  parameter int H_FP       = 16,
  parameter int H_SYNC     = 96,
  parameter int H_BP       = 48,
  parameter int V_ACT      = 480,
  parameter int V_FP       = 10,
  parameter int V_SYNC     = 2,
  parameter int V_BP       = 33,
  parameter int LAYER_W    = 8,
  parameter int FIFO_DEPTH = 8,
  parameter int ADDR_W     = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  output logic                 mem_req,
  output logic [ADDR_W-1:0]    mem_addr,
  input  logic                 mem_gnt,
  input  logic                 mem_rvalid,
  input  logic [2*LAYER_W-1:0] mem_rdata,
  output logic                 fifo_full,
  output logic                 hsync_n,
  output logic                 vsync_n,
  output logic                 blank,
  output logic [LAYER_W-1:0]   rgb,
  output logic                 underflow_err
);

  localparam int WORD_W    = 2 * LAYER_W;
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1);
  localparam int FRAME_PIX = H_ACT * V_ACT;

  // upper code wins unless it is the transparent value zero
  function automatic logic [LAYER_W-1:0] compose(logic [WORD_W-1:0] w);
    logic [LAYER_W-1:0] up, lo;
    up = w[WORD_W-1:LAYER_W];
    lo = w[LAYER_W-1:0];
    return (up != '0) ? up : lo;
  endfunction

  lsf_scan_t          scan;
  logic               pix_en, frame_restart, scan_act;
  logic [WORD_W-1:0]  fifo_rdata;
  logic [LVL_W-1:0]   fifo_level;
  logic               fifo_empty;
  logic               fifo_pop, fifo_underflow;
  logic [LAYER_W-1:0] comp_pix;

  lsf_timing #(
    .CLK_DIV(CLK_DIV), .H_ACT(H_ACT), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
  ) u_tim (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .scan(scan),
    .frame_restart(frame_restart)
  );

  lsf_fetch #(.ADDR_W(ADDR_W), .DEPTH(FIFO_DEPTH), .FRAME_PIX(FRAME_PIX)) u_fet (
    .clk(clk), .rst_n(rst_n), .restart(frame_restart), .fifo_level(fifo_level),
    .gnt(mem_gnt), .rsp_valid(mem_rvalid), .req(mem_req), .addr(mem_addr)
  );

  lsf_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_q (
    .clk(clk), .rst_n(rst_n), .push(mem_rvalid), .wdata(mem_rdata),
    .pop(fifo_pop), .rdata(fifo_rdata), .level(fifo_level),
    .empty(fifo_empty), .full(fifo_full)
  );

  assign scan_act       = scan.act;
  assign fifo_pop       = pix_en && scan_act && !fifo_empty;
  assign fifo_underflow = pix_en && scan_act && fifo_empty;
  assign comp_pix       = compose(fifo_rdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hsync_n       <= 1'b1;
      vsync_n       <= 1'b1;
      blank         <= 1'b1;
      rgb           <= '0;
      underflow_err <= 1'b0;
    end else begin
      if (pix_en) begin
        hsync_n <= scan.hs_n;
        vsync_n <= scan.vs_n;
        blank   <= !scan_act;
        rgb     <= fifo_pop ? comp_pix : '0;
      end
      if (fifo_underflow) underflow_err <= 1'b1;
    end
  end

endmodule

// File: rtl/lsf_engine_chk.sv
module lsf_engine_chk #(
  parameter int AW    = 24,
  parameter int LW    = 8,
  parameter int LVL_W = 4,
  parameter int DEPTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_en,
  input logic             frame_restart,
  input logic             fifo_underflow,
  input logic [LVL_W-1:0] fifo_level,
  input logic             fifo_full,
  input logic             mem_req,
  input logic             mem_gnt,
  input logic [AW-1:0]    mem_addr,
  input logic             mem_rvalid,
  input logic             hsync_n,
  input logic             vsync_n,
  input logic             blank,
  input logic [LW-1:0]    rgb,
  input logic             underflow_err
);

  // R5
  req_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !fifo_full);

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt && !frame_restart) |=> (mem_req && $stable(mem_addr)));

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rvalid |-> (fifo_level < LVL_W'(DEPTH)));

  // R8
  blank_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> (rgb == '0));

  // R3
  vsync_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync_n |-> blank);

  // R4
  tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> ($stable(blank) && $stable(hsync_n) && $stable(vsync_n) && $stable(rgb)));

  // R9
  err_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_underflow |=> underflow_err);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_err |=> underflow_err);

endmodule

bind lsf_engine lsf_engine_chk #(
  .AW(ADDR_W), .LW(LAYER_W), .LVL_W(LVL_W), .DEPTH(FIFO_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .frame_restart(frame_restart),
  .fifo_underflow(fifo_underflow), .fifo_level(fifo_level), .fifo_full(fifo_full),
  .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
  .hsync_n(hsync_n), .vsync_n(vsync_n), .blank(blank), .rgb(rgb),
  .underflow_err(underflow_err)
);

// File: tb/sim_lsf_engine.sv
module sim_lsf_engine;

  localparam int CLK_PERIOD = 10;
  localparam int DIV    = 4;
  localparam int H_ACT  = 8, H_FP = 2, H_SYNC = 3, H_BP = 2;
  localparam int V_ACT  = 4, V_FP = 1, V_SYNC = 2, V_BP = 1;
  localparam int H_TOT  = H_ACT + H_FP + H_SYNC + H_BP;
  localparam int V_TOT  = V_ACT + V_FP + V_SYNC + V_BP;
  localparam int FRAME  = H_ACT * V_ACT;
  localparam int DEPTH  = 8;
  localparam int AW     = 8;
  localparam int LW     = 8;

  // {upper, lower, expected shown code}
  localparam logic [23:0] VEC [8] = '{
    {8'h00, 8'h00, 8'h00},
    {8'h00, 8'h5A, 8'h5A},
    {8'h3C, 8'h00, 8'h3C},
    {8'h3C, 8'hA5, 8'h3C},
    {8'hFF, 8'h01, 8'hFF},
    {8'h01, 8'hFF, 8'h01},
    {8'h80, 8'h7E, 8'h80},
    {8'h00, 8'hFF, 8'hFF}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mem_req, mem_gnt, mem_rvalid, fifo_full;
  logic [AW-1:0] mem_addr;
  logic [2*LW-1:0] mem_rdata;
  logic hsync_n, vsync_n, blank, underflow_err;
  logic [LW-1:0] rgb;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lsf_engine #(
    .CLK_DIV(DIV), .H_ACT(H_ACT), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .LAYER_W(LW), .FIFO_DEPTH(DEPTH), .ADDR_W(AW)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .fifo_full(fifo_full), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .blank(blank), .rgb(rgb), .underflow_err(underflow_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  // memory model: pseudo-random grants, fixed 3-cycle read latency
  logic [7:0]  lfsr = 8'hA7;
  logic        stall = 1'b0;
  logic [2:0]  pv = '0;
  logic [15:0] pd0, pd1, pd2;

  function automatic logic [15:0] word_at(logic [AW-1:0] a);
    return VEC[a % 8][23:8];
  endfunction

  assign mem_gnt    = rst_n && mem_req && lfsr[0] && !stall;
  assign mem_rvalid = pv[2];
  assign mem_rdata  = pd2;

  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (!rst_n) pv <= '0;
    else        pv <= {pv[1:0], mem_req && mem_gnt};
    pd0 <= word_at(mem_addr);
    pd1 <= pd0;
    pd2 <= pd1;
  end

  // continuous monitor of raster timing and fetch order
  int hs_run = 0, hs_per = 0, vs_run = 0, act_run = 0, act_lines = 0;
  int gcount = 0, exp_addr = 0;
  bit hs_seen = 0, vs_seen = 0, hs_prev = 1, vs_prev = 1, bl_prev = 1;
  bit fetch_chk = 1, uf_chk = 0;
  bit p_req = 0, p_gnt = 0;
  logic [AW-1:0] p_addr = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      hs_per++;
      if (!hsync_n) hs_run++;
      if (hsync_n && !hs_prev) begin
        chk(hs_run == H_SYNC * DIV, "R2", "hsync low clocks", hs_run, H_SYNC * DIV);
        hs_run = 0;
      end
      if (!hsync_n && hs_prev) begin
        if (hs_seen) chk(hs_per == H_TOT * DIV, "R4", "line clocks", hs_per, H_TOT * DIV);
        hs_seen = 1;
        hs_per = 0;
      end
      if (!vsync_n) vs_run++;
      if (vsync_n && !vs_prev) begin
        chk(vs_run == V_SYNC * H_TOT * DIV, "R3", "vsync low clocks", vs_run,
            V_SYNC * H_TOT * DIV);
        vs_run = 0;
      end
      if (!blank) act_run++;
      if (blank && !bl_prev) begin
        chk(act_run == H_ACT * DIV, "R2", "visible clocks per line", act_run, H_ACT * DIV);
        act_run = 0;
        act_lines++;
      end
      if (!vsync_n && vs_prev) begin
        if (vs_seen) chk(act_lines == V_ACT, "R3", "visible lines", act_lines, V_ACT);
        act_lines = 0;
        vs_seen = 1;
      end
      if (blank) chk(rgb == '0, "R8", "rgb while blanked", rgb, 0);
      if (uf_chk && underflow_err && !blank)
        chk(rgb == '0, "R9", "starved pixel", rgb, 0);
      if (fetch_chk && mem_req && mem_gnt) begin
        chk(int'(mem_addr) == exp_addr, "R6", "granted address", mem_addr, exp_addr);
        exp_addr = (exp_addr + 1) % FRAME;
      end
      if (mem_req && mem_gnt) gcount++;
      if (fetch_chk && p_req && !p_gnt)
        chk(mem_req && mem_addr == p_addr, "R5", "request held", mem_addr, p_addr);
      p_req = mem_req;
      p_gnt = mem_gnt;
      p_addr = mem_addr;
      hs_prev = hsync_n;
      vs_prev = vsync_n;
      bl_prev = blank;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, got 0 expected 1");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(hsync_n && vsync_n, "R1", "syncs idle", {hsync_n, vsync_n}, 3);
    chk(blank == 1'b1, "R1", "blank", blank, 1);
    chk(rgb == '0 && underflow_err == 1'b0, "R1", "rgb/err", {rgb, underflow_err}, 0);
    chk(fifo_full == 1'b0, "R1", "fifo_full", fifo_full, 0);
    chk(mem_req && mem_addr == '0, "R1", "first request", {mem_req, mem_addr}, 9'h100);
    @(posedge clk);
    rst_n <= 1'b1;

    // R10/R5: queue fills during blanking, then requests stop
    repeat (50) @(negedge clk);
    chk(fifo_full == 1'b1, "R10", "fifo_full after fill", fifo_full, 1);
    chk(mem_req == 1'b0, "R5", "no request when full", mem_req, 0);
    chk(gcount == DEPTH, "R10", "words requested during fill", gcount, DEPTH);

    // R7: one whole frame of composed pixels, vector table walked in fetch order
    do @(negedge clk); while (vsync_n);
    for (int k = 0; k < FRAME; k++) begin
      do @(negedge clk); while (blank);
      chk(rgb == VEC[k % 8][7:0], "R7", "composed pixel", rgb, VEC[k % 8][7:0]);
      repeat (DIV - 1) @(negedge clk);
    end

    // R9: starve the queue during visible video
    chk(underflow_err == 1'b0, "R9", "no error in normal run", underflow_err, 0);
    stall = 1'b1;
    fetch_chk = 1'b0;
    uf_chk = 1'b1;
    repeat (H_TOT * V_TOT * DIV + 120) @(negedge clk);
    chk(underflow_err == 1'b1, "R9", "error after starvation", underflow_err, 1);
    uf_chk = 1'b0;
    stall = 1'b0;
    repeat (H_TOT * V_TOT * DIV) @(negedge clk);
    chk(underflow_err == 1'b1, "R9", "error stays set", underflow_err, 1);

    finish_run();
  end

endmodule